// File: doc/BRIEF.md
# Cache Line Coherency Probe Responder

This block sits on the master side of a coherent cache. It keeps the coherency state for a small set of cache lines. For each line it stores an address tag, an opaque data word and four flags: valid, shared, owner and dirty. The interconnect sends probes that ask the cache either to give up a line or to downgrade it to shared. The block looks the line up and answers with exactly one reply. The reply is a bare success token on the probe-response stream, or a tagged write on the write-command stream when the line holds dirty data that this cache is responsible for. After a write it waits for the write response before it accepts the next probe.

The local cache controller loads line entries through an update port and reads the current state of an entry through a combinational query port. A local write-in-flight indication holds off new probes, so probes never overtake writes the cache already has outstanding.

Top module: `coh_probe_agent`

## Requirements
- R1: After reset every entry reads back flags 4'b0000, `pcmd_ready` is 1, and both `prsp_valid` and `wcmd_valid` are 0.
- R2: A probe hits only an entry whose valid flag (bit 3 of the flags field {valid,shared,owner,dirty}) is set and whose address matches. An entry with valid clear is skipped whatever its other bits hold. A miss is answered with a probe success and changes no entry.
- R3: A make-invalid probe (op 0) that hits a line with owner and dirty set issues a write with kind 0 (invalidate). The write carries the probe ID, the probe address and the line data. The line's flags become 4'b0000.
- R4: A make-shared probe (op 1) that hits a line with owner and dirty set issues a write with kind 1 (share). The write carries the probe ID, address and line data. The line's flags become 4'b1110 (valid, shared, owner, clean).
- R5: A make-invalid probe that hits a line without both owner and dirty set answers with a probe success and sets the line's flags to 4'b0000, with no write.
- R6: A make-shared probe that hits a line without both owner and dirty set answers with a probe success. It sets the shared flag and leaves valid, owner and dirty as they were.
- R7: Each accepted probe produces exactly one reply on the cycle after acceptance. A success reply carries the probe's ID on `prsp_id`. The two reply streams are never valid together.
- R8: `pcmd_ready` is 0 while `wr_inflight` is 1.
- R9: A reply whose ready is low stays valid, with all of its fields unchanged, until it is taken.
- R10: An update loads the index given on the port with the new address, flags and data from the next cycle on. No probe is accepted in a cycle in which an update is applied.
- R11: After a write reply is taken, `pcmd_ready` stays 0 until a write response is received. `wrsp_ready` is 1 only while the block waits for that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcmd_valid | input | 1 | Probe command valid |
| pcmd_ready | output | 1 | Probe command accepted |
| pcmd_op | input | 1 | 0 make-invalid, 1 make-shared |
| pcmd_addr | input | ADDR_W | Probed line address |
| pcmd_id | input | ID_W | Probe identifier |
| prsp_valid | output | 1 | Probe success reply valid |
| prsp_ready | input | 1 | Probe success reply taken |
| prsp_id | output | ID_W | ID of the probe being answered |
| wcmd_valid | output | 1 | Write reply valid |
| wcmd_ready | input | 1 | Write reply taken |
| wcmd_kind | output | 1 | 0 invalidate, 1 share |
| wcmd_addr | output | ADDR_W | Written line address |
| wcmd_id | output | ID_W | ID of the probe that caused the write |
| wcmd_data | output | DATA_W | Line data |
| wrsp_valid | input | 1 | Write response valid |
| wrsp_ready | output | 1 | Write response accepted |
| wr_inflight | input | 1 | Local write outstanding; holds off probes |
| upd_en | input | 1 | Load a line entry |
| upd_idx | input | IDX_W | Entry index to load |
| upd_addr | input | ADDR_W | New line address |
| upd_flags | input | 4 | New flags {valid,shared,owner,dirty} |
| upd_data | input | DATA_W | New line data |
| qry_idx | input | IDX_W | Entry index to read |
| qry_addr | output | ADDR_W | Address of queried entry |
| qry_flags | output | 4 | Flags of queried entry |

## Verification
The main sweep loads one entry with each of the sixteen flag patterns. It probes that entry with both opcodes. This separates the invalid-entry case (ignored, flags unchanged), the owner-and-dirty case (tagged write of the right kind) and the remaining cases (success with an invalidate or share update). The flags are read back after each probe. A probe to an absent address and a probe whose address also matches a stale invalid entry at a lower index show that only valid entries can hit. The write path is stalled on both handshakes, and the local write-in-flight input is held, to show hold-off and stability.

// File: rtl/coh_probe_pkg.sv
package coh_probe_pkg;

    // Flag order is {valid, shared, owner, dirty}, valid in the MSB.
    typedef struct packed {
        logic valid;
        logic shared;
        logic owner;
        logic dirty;
    } coh_flags_t;

    typedef enum logic {
        PRB_MAKE_INVALID = 1'b0,
        PRB_MAKE_SHARED  = 1'b1
    } prb_op_e;

    typedef enum logic {
        WR_INVALIDATE = 1'b0,
        WR_SHARE      = 1'b1
    } wr_kind_e;

    typedef enum logic [1:0] {
        AG_IDLE,
        AG_PRSP,
        AG_WCMD,
        AG_WRSP
    } agent_st_e;

    // A line must write back only when it owns dirty data.
    function automatic logic needs_writeback(coh_flags_t f);
        return f.valid & f.owner & f.dirty;
    endfunction

    // Flags left in a line after a probe has hit it.
    function automatic coh_flags_t flags_after_probe(prb_op_e op, coh_flags_t f);
        coh_flags_t r;
        if (op == PRB_MAKE_INVALID) begin
            r = '0;
        end else if (needs_writeback(f)) begin
            r = '{valid: 1'b1, shared: 1'b1, owner: 1'b1, dirty: 1'b0};
        end else begin
            r = f;
            r.shared = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_probe_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int IDX_W     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              upd_en,
    input  logic [IDX_W-1:0]                  upd_idx,
    input  logic [ADDR_W-1:0]                 upd_addr,
    input  logic [3:0]                        upd_flags,
    input  logic [DATA_W-1:0]                 upd_data,
    input  logic                              prb_wr_en,
    input  logic [IDX_W-1:0]                  prb_wr_idx,
    input  logic [3:0]                        prb_wr_flags,
    output logic [NUM_LINES-1:0][ADDR_W-1:0]  line_addr,
    output logic [NUM_LINES-1:0][3:0]         line_flags,
    output logic [NUM_LINES-1:0][DATA_W-1:0]  line_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        coh_flags_t        flags;
    } line_t;

    line_t [NUM_LINES-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (prb_wr_en) begin
            tab_d[prb_wr_idx].flags = coh_flags_t'(prb_wr_flags);
        end
        // The update port wins; the responder never accepts a probe in the same cycle.
        if (upd_en) begin
            tab_d[upd_idx].addr  = upd_addr;
            tab_d[upd_idx].data  = upd_data;
            tab_d[upd_idx].flags = coh_flags_t'(upd_flags);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_out
        assign line_addr[g]  = tab_q[g].addr;
        assign line_flags[g] = tab_q[g].flags;
        assign line_data[g]  = tab_q[g].data;
    end

endmodule

// File: rtl/coh_line_match.sv
module coh_line_match #(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_LINES-1:0][ADDR_W-1:0] line_addr,
    input  logic [NUM_LINES-1:0][3:0]        line_flags,
    input  logic [ADDR_W-1:0]                look_addr,
    output logic                             hit,
    output logic [IDX_W-1:0]                 hit_idx
);

    logic [NUM_LINES-1:0] match_vec;

    // Only entries with the valid bit set may match; the other bits are ignored.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign match_vec[g] = line_flags[g][3] && (line_addr[g] == look_addr);
    end

    // The lowest matching index wins.
    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/coh_probe_fsm.sv
module coh_probe_fsm
    import coh_probe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcmd_valid,
    output logic              pcmd_ready,
    input  logic              pcmd_op,
    input  logic [ADDR_W-1:0] pcmd_addr,
    input  logic [ID_W-1:0]   pcmd_id,
    output logic              prsp_valid,
    input  logic              prsp_ready,
    output logic [ID_W-1:0]   prsp_id,
    output logic              wcmd_valid,
    input  logic              wcmd_ready,
    output logic              wcmd_kind,
    output logic [ADDR_W-1:0] wcmd_addr,
    output logic [ID_W-1:0]   wcmd_id,
    output logic [DATA_W-1:0] wcmd_data,
    input  logic              wrsp_valid,
    output logic              wrsp_ready,
    input  logic              wr_inflight,
    input  logic              upd_en,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [3:0]        hit_flags,
    input  logic [DATA_W-1:0] hit_data,
    output logic              prb_wr_en,
    output logic [IDX_W-1:0]  prb_wr_idx,
    output logic [3:0]        prb_wr_flags
);

    typedef struct packed {
        agent_st_e         st;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        wr_kind_e          kind;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        pcmd_ready   = (s_q.st == AG_IDLE) && !wr_inflight && !upd_en;
        prb_wr_en    = 1'b0;
        prb_wr_idx   = hit_idx;
        prb_wr_flags = flags_after_probe(prb_op_e'(pcmd_op), coh_flags_t'(hit_flags));

        unique case (s_q.st)
            AG_IDLE: begin
                if (pcmd_valid && pcmd_ready) begin
                    s_d.id   = pcmd_id;
                    s_d.addr = pcmd_addr;
                    s_d.data = hit_data;
                    s_d.kind = wr_kind_e'(pcmd_op);
                    prb_wr_en = hit;
                    if (hit && needs_writeback(coh_flags_t'(hit_flags))) begin
                        s_d.st = AG_WCMD;
                    end else begin
                        s_d.st = AG_PRSP;
                    end
                end
            end
            AG_PRSP: begin
                if (prsp_ready) s_d.st = AG_IDLE;
            end
            AG_WCMD: begin
                if (wcmd_ready) s_d.st = AG_WRSP;
            end
            AG_WRSP: begin
                if (wrsp_valid) s_d.st = AG_IDLE;
            end
            default: s_d.st = AG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: AG_IDLE, kind: WR_INVALIDATE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign prsp_valid = (s_q.st == AG_PRSP);
    assign prsp_id    = s_q.id;
    assign wcmd_valid = (s_q.st == AG_WCMD);
    assign wcmd_kind  = s_q.kind;
    assign wcmd_addr  = s_q.addr;
    assign wcmd_id    = s_q.id;
    assign wcmd_data  = s_q.data;
    assign wrsp_ready = (s_q.st == AG_WRSP);

endmodule

// File: rtl/coh_probe_agent.sv
module coh_probe_agent #(
    parameter int  NUM_LINES = 4,
    parameter int  ADDR_W    = 8,
    parameter int  ID_W      = 4,
    parameter int  DATA_W    = 16,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcmd_valid,
    output logic              pcmd_ready,
    input  logic              pcmd_op,
    input  logic [ADDR_W-1:0] pcmd_addr,
    input  logic [ID_W-1:0]   pcmd_id,
    output logic              prsp_valid,
    input  logic              prsp_ready,
    output logic [ID_W-1:0]   prsp_id,
    output logic              wcmd_valid,
    input  logic              wcmd_ready,
    output logic              wcmd_kind,
    output logic [ADDR_W-1:0] wcmd_addr,
    output logic [ID_W-1:0]   wcmd_id,
    output logic [DATA_W-1:0] wcmd_data,
    input  logic              wrsp_valid,
    output logic              wrsp_ready,
    input  logic              wr_inflight,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [3:0]        upd_flags,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [IDX_W-1:0]  qry_idx,
    output logic [ADDR_W-1:0] qry_addr,
    output logic [3:0]        qry_flags
);

    logic [NUM_LINES-1:0][ADDR_W-1:0] line_addr;
    logic [NUM_LINES-1:0][3:0]        line_flags;
    logic [NUM_LINES-1:0][DATA_W-1:0] line_data;
    logic                             hit;
    logic [IDX_W-1:0]                 hit_idx;
    logic                             prb_wr_en;
    logic [IDX_W-1:0]                 prb_wr_idx;
    logic [3:0]                       prb_wr_flags;

    coh_line_table #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_en       (upd_en),
        .upd_idx      (upd_idx),
        .upd_addr     (upd_addr),
        .upd_flags    (upd_flags),
        .upd_data     (upd_data),
        .prb_wr_en    (prb_wr_en),
        .prb_wr_idx   (prb_wr_idx),
        .prb_wr_flags (prb_wr_flags),
        .line_addr    (line_addr),
        .line_flags   (line_flags),
        .line_data    (line_data)
    );

    coh_line_match #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_match (
        .line_addr  (line_addr),
        .line_flags (line_flags),
        .look_addr  (pcmd_addr),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    coh_probe_fsm #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pcmd_valid   (pcmd_valid),
        .pcmd_ready   (pcmd_ready),
        .pcmd_op      (pcmd_op),
        .pcmd_addr    (pcmd_addr),
        .pcmd_id      (pcmd_id),
        .prsp_valid   (prsp_valid),
        .prsp_ready   (prsp_ready),
        .prsp_id      (prsp_id),
        .wcmd_valid   (wcmd_valid),
        .wcmd_ready   (wcmd_ready),
        .wcmd_kind    (wcmd_kind),
        .wcmd_addr    (wcmd_addr),
        .wcmd_id      (wcmd_id),
        .wcmd_data    (wcmd_data),
        .wrsp_valid   (wrsp_valid),
        .wrsp_ready   (wrsp_ready),
        .wr_inflight  (wr_inflight),
        .upd_en       (upd_en),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .hit_flags    (line_flags[hit_idx]),
        .hit_data     (line_data[hit_idx]),
        .prb_wr_en    (prb_wr_en),
        .prb_wr_idx   (prb_wr_idx),
        .prb_wr_flags (prb_wr_flags)
    );

    assign qry_addr  = line_addr[qry_idx];
    assign qry_flags = line_flags[qry_idx];

endmodule

// File: rtl/coh_probe_agent_chk.sv
module coh_probe_agent_chk #(
    parameter int  NUM_LINES = 4,
    parameter int  ADDR_W    = 8,
    parameter int  ID_W      = 4,
    parameter int  DATA_W    = 16,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pcmd_valid,
    input logic              pcmd_ready,
    input logic              pcmd_op,
    input logic [ADDR_W-1:0] pcmd_addr,
    input logic [ID_W-1:0]   pcmd_id,
    input logic              prsp_valid,
    input logic              prsp_ready,
    input logic [ID_W-1:0]   prsp_id,
    input logic              wcmd_valid,
    input logic              wcmd_ready,
    input logic              wcmd_kind,
    input logic [ADDR_W-1:0] wcmd_addr,
    input logic [ID_W-1:0]   wcmd_id,
    input logic [DATA_W-1:0] wcmd_data,
    input logic              wrsp_valid,
    input logic              wrsp_ready,
    input logic              wr_inflight,
    input logic              upd_en,
    input logic [IDX_W-1:0]  upd_idx,
    input logic [ADDR_W-1:0] upd_addr,
    input logic [3:0]        upd_flags,
    input logic [DATA_W-1:0] upd_data,
    input logic [IDX_W-1:0]  qry_idx,
    input logic [ADDR_W-1:0] qry_addr,
    input logic [3:0]        qry_flags
);

    // R8
    inflight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inflight |-> !pcmd_ready);

    // R10
    upd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> !pcmd_ready);

    // R7
    single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcmd_valid && pcmd_ready) |=> (prsp_valid != wcmd_valid));

    // R7
    reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prsp_valid && wcmd_valid));

    // R7
    prsp_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcmd_valid && pcmd_ready) |=> (!prsp_valid || prsp_id == $past(pcmd_id)));

    // R3
    wcmd_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcmd_valid && pcmd_ready) |=> (!wcmd_valid || (wcmd_id == $past(pcmd_id)
                                        && wcmd_addr == $past(pcmd_addr))));

    // R9
    prsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prsp_valid && !prsp_ready) |=> (prsp_valid && $stable(prsp_id)));

    // R9
    wcmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wcmd_valid && !wcmd_ready) |=>
            (wcmd_valid && $stable({wcmd_kind, wcmd_addr, wcmd_id, wcmd_data})));

    // R11
    wrsp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wcmd_valid && wcmd_ready) |=> (wrsp_ready && !pcmd_ready));

    // R11
    wrsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrsp_ready |-> (!prsp_valid && !wcmd_valid && !pcmd_ready));

endmodule

bind coh_probe_agent coh_probe_agent_chk #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/coh_probe_agent_bench.sv
`timescale 1ns/1ps
module coh_probe_agent_bench;

    localparam int NL = 4;
    localparam int AW = 8;
    localparam int IW = 4;
    localparam int DW = 16;
    localparam int XW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pcmd_valid = 1'b0;
    logic          pcmd_ready;
    logic          pcmd_op = 1'b0;
    logic [AW-1:0] pcmd_addr = '0;
    logic [IW-1:0] pcmd_id = '0;
    logic          prsp_valid;
    logic          prsp_ready = 1'b0;
    logic [IW-1:0] prsp_id;
    logic          wcmd_valid;
    logic          wcmd_ready = 1'b0;
    logic          wcmd_kind;
    logic [AW-1:0] wcmd_addr;
    logic [IW-1:0] wcmd_id;
    logic [DW-1:0] wcmd_data;
    logic          wrsp_valid = 1'b0;
    logic          wrsp_ready;
    logic          wr_inflight = 1'b0;
    logic          upd_en = 1'b0;
    logic [XW-1:0] upd_idx = '0;
    logic [AW-1:0] upd_addr = '0;
    logic [3:0]    upd_flags = '0;
    logic [DW-1:0] upd_data = '0;
    logic [XW-1:0] qry_idx = '0;
    logic [AW-1:0] qry_addr;
    logic [3:0]    qry_flags;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    coh_probe_agent #(.NUM_LINES(NL), .ADDR_W(AW), .ID_W(IW), .DATA_W(DW)) u_coh_probe_agent (
        .clk(clk), .rst_n(rst_n),
        .pcmd_valid(pcmd_valid), .pcmd_ready(pcmd_ready), .pcmd_op(pcmd_op),
        .pcmd_addr(pcmd_addr), .pcmd_id(pcmd_id),
        .prsp_valid(prsp_valid), .prsp_ready(prsp_ready), .prsp_id(prsp_id),
        .wcmd_valid(wcmd_valid), .wcmd_ready(wcmd_ready), .wcmd_kind(wcmd_kind),
        .wcmd_addr(wcmd_addr), .wcmd_id(wcmd_id), .wcmd_data(wcmd_data),
        .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wr_inflight(wr_inflight),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_addr(upd_addr),
        .upd_flags(upd_flags), .upd_data(upd_data),
        .qry_idx(qry_idx), .qry_addr(qry_addr), .qry_flags(qry_flags)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic load_line(input int idx, input int addr, input int fl, input int data);
        @(negedge clk);
        upd_en = 1'b1; upd_idx = XW'(idx); upd_addr = AW'(addr);
        upd_flags = 4'(fl); upd_data = DW'(data);
        #1 check(pcmd_ready == 1'b0, "R10 ready during update", int'(pcmd_ready), 0);
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic query(input int idx, output int fl, output int ad);
        qry_idx = XW'(idx);
        #1;
        fl = int'(qry_flags);
        ad = int'(qry_addr);
    endtask

    // Entered just after a negedge; leaves just after the negedge following acceptance.
    task automatic send_probe(input int op, input int addr, input int id);
        pcmd_valid = 1'b1; pcmd_op = op[0]; pcmd_addr = AW'(addr); pcmd_id = IW'(id);
        forever begin
            #1;
            if (pcmd_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        pcmd_valid = 1'b0;
    endtask

    task automatic expect_success(input int id, input string req);
        #1;
        check(prsp_valid == 1'b1, {req, " success valid"}, int'(prsp_valid), 1);
        check(wcmd_valid == 1'b0, {req, " no write"}, int'(wcmd_valid), 0);
        check(int'(prsp_id) == id, {req, " success id"}, int'(prsp_id), id);
        @(negedge clk);
        #1 check(prsp_valid == 1'b1 && int'(prsp_id) == id, "R9 success held", int'(prsp_id), id);
        prsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        prsp_ready = 1'b0;
        #1 check(pcmd_ready == 1'b1 && prsp_valid == 1'b0, "R7 idle after success",
                 int'(pcmd_ready), 1);
    endtask

    task automatic expect_write(input int kind, input int addr, input int id, input int data,
                                input string req);
        #1;
        check(wcmd_valid == 1'b1 && prsp_valid == 1'b0, {req, " write valid"}, int'(wcmd_valid), 1);
        check(int'(wcmd_kind) == kind, {req, " write kind"}, int'(wcmd_kind), kind);
        check(int'(wcmd_id) == id, {req, " write id"}, int'(wcmd_id), id);
        check(int'(wcmd_addr) == addr, {req, " write addr"}, int'(wcmd_addr), addr);
        check(int'(wcmd_data) == data, {req, " write data"}, int'(wcmd_data), data);
        @(negedge clk);
        #1 check(wcmd_valid == 1'b1 && int'(wcmd_data) == data && int'(wcmd_id) == id,
                 "R9 write held", int'(wcmd_data), data);
        wcmd_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wcmd_ready = 1'b0;
        for (int k = 0; k < 2; k++) begin
            #1 check(pcmd_ready == 1'b0 && wcmd_valid == 1'b0 && wrsp_ready == 1'b1,
                     "R11 waiting for write response", int'(pcmd_ready), 0);
            @(negedge clk);
        end
        wrsp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wrsp_valid = 1'b0;
        #1 check(pcmd_ready == 1'b1 && wrsp_ready == 1'b0, "R11 idle after response",
                 int'(pcmd_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int fl;
        int ad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        #1;
        check(pcmd_ready == 1'b1, "R1 ready", int'(pcmd_ready), 1);
        check(prsp_valid == 1'b0 && wcmd_valid == 1'b0, "R1 replies idle",
              int'({prsp_valid, wcmd_valid}), 0);
        for (int e = 0; e < NL; e++) begin
            query(e, fl, ad);
            check(fl == 0, "R1 entry flags", fl, 0);
        end

        // Main sweep: every flag pattern against both probe types.
        for (int op = 0; op < 2; op++) begin
            for (int f = 0; f < 16; f++) begin
                int data;
                int id;
                int exp_fl;
                bit v;
                bit od;
                data = 16'hA000 + f * 16 + op;
                id   = (f ^ (op << 3)) & 15;
                v    = f[3];
                od   = f[1] & f[0];
                load_line(2, 8'h40, f, data);
                query(2, fl, ad);
                check(fl == f && ad == 8'h40, "R10 entry loaded", fl, f);
                send_probe(op, 8'h40, id);
                if (!v) begin
                    expect_success(id, "R2 invalid entry");
                    exp_fl = f;
                end else if (od) begin
                    expect_write(op, 8'h40, id, data, (op == 0) ? "R3" : "R4");
                    exp_fl = (op == 0) ? 0 : 4'b1110;
                end else begin
                    expect_success(id, (op == 0) ? "R5" : "R6");
                    exp_fl = (op == 0) ? 0 : (f | 4'b0100);
                end
                query(2, fl, ad);
                check(fl == exp_fl,
                      !v ? "R2 flags untouched" : od ? ((op == 0) ? "R3 flags" : "R4 flags")
                                                     : ((op == 0) ? "R5 flags" : "R6 flags"),
                      fl, exp_fl);
                @(negedge clk);
            end
        end

        // R2: absent address changes nothing.
        load_line(1, 8'h21, 4'b1011, 16'h1234);
        send_probe(0, 8'h99, 7);
        expect_success(7, "R2 miss");
        query(1, fl, ad);
        check(fl == 4'b1011, "R2 miss leaves entry", fl, 4'b1011);

        // R2: stale invalid entry at a lower index does not shadow a valid one.
        load_line(0, 8'h55, 4'b0111, 16'h0BAD);
        load_line(3, 8'h55, 4'b1011, 16'hBEEF);
        send_probe(0, 8'h55, 5);
        expect_write(0, 8'h55, 5, 16'hBEEF, "R2 skip invalid, R3");
        query(3, fl, ad);
        check(fl == 0, "R3 valid entry invalidated", fl, 0);
        query(0, fl, ad);
        check(fl == 4'b0111, "R2 invalid entry untouched", fl, 4'b0111);

        // R8: local write in flight holds the probe off.
        @(negedge clk);
        wr_inflight = 1'b1;
        pcmd_valid = 1'b1; pcmd_op = 1'b1; pcmd_addr = 8'h21; pcmd_id = 4'd9;
        for (int k = 0; k < 3; k++) begin
            #1 check(pcmd_ready == 1'b0 && prsp_valid == 1'b0 && wcmd_valid == 1'b0,
                     "R8 held off", int'(pcmd_ready), 0);
            @(negedge clk);
        end
        wr_inflight = 1'b0;
        send_probe(1, 8'h21, 9);
        expect_write(1, 8'h21, 9, 16'h1234, "R8 released, R4");
        query(1, fl, ad);
        check(fl == 4'b1110, "R4 after hold", fl, 4'b1110);

        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule